// File: doc/BRIEF.md
# Opcode Group Decoder for an 8-bit Accumulator CPU

This block is the first decode stage of a small 8-bit accumulator processor. It takes one opcode byte and splits it into three fields: the operation field in bits 7:5, the mode field in bits 4:2 and the group field in bits 1:0. From these fields it produces a one-hot operation class, an addressing-mode code, the primary destination and a flag-update enable. It also raises an illegal flag for any opcode it does not recognise.

Each group field value is handled by its own sub-decoder. In group 01, the operation field picks the arithmetic or logic operation and the mode field picks the addressing mode. In group 10, operations 0 to 3 are shifts and rotates. In the upper half of group 10 and in all of group 00, certain mode-field values do not select an addressing mode. Instead they turn the opcode into a single-byte register operation, a branch, a flag set/clear or a control-flow operation.

The decoder is purely combinational. The pipeline that instantiates it registers its outputs. The block does not execute instructions, fetch operands or count cycles.

Top module: `opc_group_decoder`

## Requirements
- R1: For group 01, `op_class_o` depends only on the operation field. Operation 0, 1 and 2 (OR, AND, XOR) give class bit 0 (logic). Operation 3 gives bit 1 (add). Operation 4 gives bit 5 (store). Operation 5 gives bit 4 (load). Operation 6 gives bit 3 (compare). Operation 7 gives bit 2 (subtract). `dest_o` is 5 (memory) for store, 0 (none) for compare and 1 (A) for all others.
- R2: For group 01, `addr_mode_o` is set by the mode field: 0 gives 8 (zero-page indexed-indirect by X), 1 gives 3 (zero page), 2 gives 2 (immediate), 3 gives 5 (absolute), 4 gives 9 (zero-page indirect indexed by Y), 5 gives 4 (zero page + X), 6 gives 7 (absolute + Y) and 7 gives 6 (absolute + X). Store with mode 2 is illegal.
- R3: For group 10 with operation 0 to 3 (shift left, rotate left, shift right, rotate right), the class is bit 6. Mode 1 gives address mode 3, mode 2 gives 1 (accumulator), mode 3 gives 5, mode 5 gives 4 and mode 7 gives 6. The destination is 1 for the accumulator mode and 5 for the others. Modes 0, 4 and 6 are illegal.
- R4: In group 10 the following combinations override the normal decode. Operation 4 with mode 2 is X-to-A (class bit 8, dest 1). Operation 6 with mode 2 is decrement X (class bit 7, dest 2). Operation 7 with mode 2 is no-operation (class bit 12, dest 0). Operation 4 with mode 6 is X-to-stack-pointer (class bit 8, dest 4). Operation 5 with mode 6 is stack-pointer-to-X (class bit 8, dest 2). All of these use address mode 0. Every other operation 4 to 7 combination in group 10 is illegal.
- R5: In group 00 with mode 4, operations 4, 6 and 7 are branches on carry clear, not zero and zero. They give class bit 9, address mode 10 (relative) and dest 6 (program counter).
- R6: In group 00 with mode 2, operations 4 and 6 (decrement and increment Y) give class bit 7 with dest 3, and operation 7 (increment X) gives class bit 7 with dest 2. Operation 4 with mode 6 is Y-to-A (class bit 8, dest 1). All of these use address mode 0.
- R7: In group 00 with mode 6, operations 1, 5, 6 and 7 (set carry, clear overflow, clear decimal, set decimal) give class bit 10, address mode 0, dest 0 and flag update 1.
- R8: In group 00 with mode 0, operations 0 to 3 (break, call, return-from-interrupt, return) give class bit 11 and dest 6. The call uses address mode 5 and the others use 0.
- R9: Every group 11 opcode, and every combination not named in R1 to R8, drives `illegal_o` to 1. In that case `op_class_o` is 0, `addr_mode_o` is 0, `dest_o` is 0 and `flag_upd_o` is 0.
- R10: For every legal opcode, `op_class_o` has exactly one bit set and `illegal_o` is 0.
- R11: `flag_upd_o` is 1 for the logic, add, subtract, compare, load, shift, increment/decrement and flag classes. It is also 1 for transfers into A or X, and for break and return-from-interrupt. It is 0 for store, branch, no-operation, call, return and X-to-stack-pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 8 | Opcode byte to decode |
| op_class_o | output | 13 | One-hot operation class, all zero when illegal |
| addr_mode_o | output | 4 | Addressing-mode code |
| dest_o | output | 3 | Primary destination: 0 none, 1 A, 2 X, 3 Y, 4 stack pointer, 5 memory, 6 program counter |
| flag_upd_o | output | 1 | The instruction updates status flags |
| illegal_o | output | 1 | Opcode has no defined mapping |

## Verification
One opcode can match two decodes at once. The normal operation-plus-mode decode of a group can apply at the same time as a mode-field override that makes the opcode a register op or branch. Operation 4 of group 10 with mode 2 is an example: it sits where an accumulator-mode store would fall. The bench sweeps all 256 opcodes, so every overlap of this kind is applied. For each opcode it computes the expected class, mode, destination and flag enable arithmetically from the three fields, and checks that the override wins wherever R4 to R8 define one and that the opcode is illegal wherever neither decode applies.

// File: rtl/opc_dec_pkg.sv
package opc_dec_pkg;

  localparam int OP_W   = 3;
  localparam int MODE_W = 3;
  localparam int GRP_W  = 2;
  localparam int OPC_W  = OP_W + MODE_W + GRP_W;
  localparam int N_CLS  = 13;
  localparam int AM_W   = 4;
  localparam int DST_W  = 3;

  typedef enum logic [3:0] {
    CLS_LOGIC  = 4'd0,
    CLS_ADD    = 4'd1,
    CLS_SUB    = 4'd2,
    CLS_CMP    = 4'd3,
    CLS_LOAD   = 4'd4,
    CLS_STORE  = 4'd5,
    CLS_SHIFT  = 4'd6,
    CLS_INCDEC = 4'd7,
    CLS_XFER   = 4'd8,
    CLS_BRANCH = 4'd9,
    CLS_FLAG   = 4'd10,
    CLS_FLOW   = 4'd11,
    CLS_NOP    = 4'd12
  } op_cls_e;

  typedef enum logic [AM_W-1:0] {
    AM_NONE = 4'd0,
    AM_ACC  = 4'd1,
    AM_IMM  = 4'd2,
    AM_ZP   = 4'd3,
    AM_ZPX  = 4'd4,
    AM_ABS  = 4'd5,
    AM_ABSX = 4'd6,
    AM_ABSY = 4'd7,
    AM_INDX = 4'd8,
    AM_INDY = 4'd9,
    AM_REL  = 4'd10
  } am_e;

  typedef enum logic [DST_W-1:0] {
    DST_NONE = 3'd0,
    DST_A    = 3'd1,
    DST_X    = 3'd2,
    DST_Y    = 3'd3,
    DST_SP   = 3'd4,
    DST_MEM  = 3'd5,
    DST_PC   = 3'd6
  } dst_e;

  typedef struct packed {
    logic    ill;
    op_cls_e cls;
    am_e     am;
    dst_e    dst;
    logic    flg;
  } dec_t;

  localparam dec_t DEC_ILLEGAL = '{ill: 1'b1, cls: CLS_NOP, am: AM_NONE,
                                   dst: DST_NONE, flg: 1'b0};

  function automatic dec_t mk_dec(op_cls_e c, am_e a, dst_e d, logic f);
    dec_t r;
    r.ill = 1'b0;
    r.cls = c;
    r.am  = a;
    r.dst = d;
    r.flg = f;
    return r;
  endfunction

endpackage

// File: rtl/opc_grp_alu.sv
module opc_grp_alu
  import opc_dec_pkg::*;
(
  input  logic [OP_W-1:0]   op_i,
  input  logic [MODE_W-1:0] mode_i,
  output dec_t              dec_o
);

  op_cls_e cls;
  dst_e    dst;
  am_e     am;

  always_comb begin
    case (op_i)
      3'd0, 3'd1, 3'd2: cls = CLS_LOGIC;
      3'd3:             cls = CLS_ADD;
      3'd4:             cls = CLS_STORE;
      3'd5:             cls = CLS_LOAD;
      3'd6:             cls = CLS_CMP;
      default:          cls = CLS_SUB;
    endcase
  end

  always_comb begin
    case (mode_i)
      3'd0:    am = AM_INDX;
      3'd1:    am = AM_ZP;
      3'd2:    am = AM_IMM;
      3'd3:    am = AM_ABS;
      3'd4:    am = AM_INDY;
      3'd5:    am = AM_ZPX;
      3'd6:    am = AM_ABSY;
      default: am = AM_ABSX;
    endcase
  end

  always_comb begin
    if (cls == CLS_STORE)     dst = DST_MEM;
    else if (cls == CLS_CMP)  dst = DST_NONE;
    else                      dst = DST_A;
  end

  always_comb begin
    if (cls == CLS_STORE && am == AM_IMM) dec_o = DEC_ILLEGAL;
    else dec_o = mk_dec(cls, am, dst, cls != CLS_STORE);
    AST_STORE_NO_FLAG: assert (!(!dec_o.ill && dec_o.cls == CLS_STORE && dec_o.flg))
      else $error("store must not update flags"); // R11
    AST_STORE_NOT_IMM: assert (!(!dec_o.ill && dec_o.cls == CLS_STORE && dec_o.am == AM_IMM))
      else $error("store with immediate mode decoded as legal"); // R2
  end

endmodule

// File: rtl/opc_grp_shift.sv
module opc_grp_shift
  import opc_dec_pkg::*;
(
  input  logic [OP_W-1:0]   op_i,
  input  logic [MODE_W-1:0] mode_i,
  output dec_t              dec_o
);

  dec_t shift_d;
  dec_t reg_d;

  // Lower half of the operation space: shifts and rotates
  always_comb begin
    case (mode_i)
      3'd1:    shift_d = mk_dec(CLS_SHIFT, AM_ZP,   DST_MEM, 1'b1);
      3'd2:    shift_d = mk_dec(CLS_SHIFT, AM_ACC,  DST_A,   1'b1);
      3'd3:    shift_d = mk_dec(CLS_SHIFT, AM_ABS,  DST_MEM, 1'b1);
      3'd5:    shift_d = mk_dec(CLS_SHIFT, AM_ZPX,  DST_MEM, 1'b1);
      3'd7:    shift_d = mk_dec(CLS_SHIFT, AM_ABSX, DST_MEM, 1'b1);
      default: shift_d = DEC_ILLEGAL;
    endcase
  end

  // Upper half: only the register-op overrides are mapped
  always_comb begin
    case ({op_i, mode_i})
      {3'd4, 3'd2}: reg_d = mk_dec(CLS_XFER,   AM_NONE, DST_A,    1'b1);
      {3'd6, 3'd2}: reg_d = mk_dec(CLS_INCDEC, AM_NONE, DST_X,    1'b1);
      {3'd7, 3'd2}: reg_d = mk_dec(CLS_NOP,    AM_NONE, DST_NONE, 1'b0);
      {3'd4, 3'd6}: reg_d = mk_dec(CLS_XFER,   AM_NONE, DST_SP,   1'b0);
      {3'd5, 3'd6}: reg_d = mk_dec(CLS_XFER,   AM_NONE, DST_X,    1'b1);
      default:      reg_d = DEC_ILLEGAL;
    endcase
  end

  always_comb begin
    dec_o = op_i[OP_W-1] ? reg_d : shift_d;
    AST_ACC_TO_A: assert (dec_o.ill || dec_o.am != AM_ACC || dec_o.dst == DST_A)
      else $error("accumulator shift not writing A"); // R3
    AST_SHIFT_LOW_OPS: assert (dec_o.ill || dec_o.cls != CLS_SHIFT || !op_i[OP_W-1])
      else $error("shift decoded in upper operation half"); // R4
  end

endmodule

// File: rtl/opc_grp_ctrl.sv
module opc_grp_ctrl
  import opc_dec_pkg::*;
(
  input  logic [OP_W-1:0]   op_i,
  input  logic [MODE_W-1:0] mode_i,
  output dec_t              dec_o
);

  dec_t flow_d, step_d, br_d, misc_d;

  always_comb begin
    case (op_i)
      3'd0:    flow_d = mk_dec(CLS_FLOW, AM_NONE, DST_PC, 1'b1);
      3'd1:    flow_d = mk_dec(CLS_FLOW, AM_ABS,  DST_PC, 1'b0);
      3'd2:    flow_d = mk_dec(CLS_FLOW, AM_NONE, DST_PC, 1'b1);
      3'd3:    flow_d = mk_dec(CLS_FLOW, AM_NONE, DST_PC, 1'b0);
      default: flow_d = DEC_ILLEGAL;
    endcase
  end

  always_comb begin
    case (op_i)
      3'd4, 3'd6: step_d = mk_dec(CLS_INCDEC, AM_NONE, DST_Y, 1'b1);
      3'd7:       step_d = mk_dec(CLS_INCDEC, AM_NONE, DST_X, 1'b1);
      default:    step_d = DEC_ILLEGAL;
    endcase
  end

  always_comb begin
    case (op_i)
      3'd4, 3'd6, 3'd7: br_d = mk_dec(CLS_BRANCH, AM_REL, DST_PC, 1'b0);
      default:          br_d = DEC_ILLEGAL;
    endcase
  end

  always_comb begin
    case (op_i)
      3'd4:                   misc_d = mk_dec(CLS_XFER, AM_NONE, DST_A,    1'b1);
      3'd1, 3'd5, 3'd6, 3'd7: misc_d = mk_dec(CLS_FLAG, AM_NONE, DST_NONE, 1'b1);
      default:                misc_d = DEC_ILLEGAL;
    endcase
  end

  always_comb begin
    case (mode_i)
      3'd0:    dec_o = flow_d;
      3'd2:    dec_o = step_d;
      3'd4:    dec_o = br_d;
      3'd6:    dec_o = misc_d;
      default: dec_o = DEC_ILLEGAL;
    endcase
    AST_BRANCH_REL: assert (dec_o.ill || dec_o.cls != CLS_BRANCH ||
                            (dec_o.am == AM_REL && dec_o.dst == DST_PC))
      else $error("branch without relative mode"); // R5
    AST_FLAG_NO_DEST: assert (dec_o.ill || dec_o.cls != CLS_FLAG ||
                              (dec_o.dst == DST_NONE && dec_o.flg))
      else $error("flag op writes a register"); // R7
  end

endmodule

// File: rtl/opc_group_decoder.sv
module opc_group_decoder
  import opc_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output logic [N_CLS-1:0] op_class_o,
  output logic [AM_W-1:0]  addr_mode_o,
  output logic [DST_W-1:0] dest_o,
  output logic             flag_upd_o,
  output logic             illegal_o
);

  localparam int GRP_LSB  = 0;
  localparam int MODE_LSB = GRP_LSB + GRP_W;
  localparam int OP_LSB   = MODE_LSB + MODE_W;

  logic [OP_W-1:0]   op_f;
  logic [MODE_W-1:0] mode_f;
  logic [GRP_W-1:0]  grp_f;
  dec_t alu_d, shf_d, ctl_d, sel_d;

  assign op_f   = opcode_i[OP_LSB +: OP_W];
  assign mode_f = opcode_i[MODE_LSB +: MODE_W];
  assign grp_f  = opcode_i[GRP_LSB +: GRP_W];

  opc_grp_alu u_alu (
    .op_i   (op_f),
    .mode_i (mode_f),
    .dec_o  (alu_d)
  );

  opc_grp_shift u_shift (
    .op_i   (op_f),
    .mode_i (mode_f),
    .dec_o  (shf_d)
  );

  opc_grp_ctrl u_ctrl (
    .op_i   (op_f),
    .mode_i (mode_f),
    .dec_o  (ctl_d)
  );

  always_comb begin
    case (grp_f)
      2'd0:    sel_d = ctl_d;
      2'd1:    sel_d = alu_d;
      2'd2:    sel_d = shf_d;
      default: sel_d = DEC_ILLEGAL;
    endcase
  end

  for (genvar k = 0; k < N_CLS; k++) begin : g_cls
    assign op_class_o[k] = !sel_d.ill && (sel_d.cls == op_cls_e'(k));
  end

  assign addr_mode_o = sel_d.am;
  assign dest_o      = sel_d.dst;
  assign flag_upd_o  = sel_d.flg;
  assign illegal_o   = sel_d.ill;

  always_comb begin
    AST_CLASS_ONEHOT: assert (illegal_o ? (op_class_o == '0) : ($countones(op_class_o) == 1))
      else $error("class vector not one-hot"); // R10
    AST_ILLEGAL_QUIET: assert (!illegal_o ||
                               (addr_mode_o == '0 && dest_o == '0 && !flag_upd_o))
      else $error("illegal opcode drives outputs"); // R9
    AST_GROUP3_ILLEGAL: assert (opcode_i[GRP_LSB +: GRP_W] != 2'd3 || illegal_o)
      else $error("group 3 opcode decoded as legal"); // R9
  end

endmodule

// File: tb/opc_group_decoder_tb.sv
module opc_group_decoder_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  opcode;
  logic [12:0] op_class;
  logic [3:0]  addr_mode;
  logic [2:0]  dest;
  logic        flag_upd;
  logic        illegal;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opc_group_decoder dut_i (
    .opcode_i    (opcode),
    .op_class_o  (op_class),
    .addr_mode_o (addr_mode),
    .dest_o      (dest),
    .flag_upd_o  (flag_upd),
    .illegal_o   (illegal)
  );

  task automatic chk(input string tag, input string what, input logic [7:0] o,
                     input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s opcode %02h %s got %0d expected %0d", tag, o, what, got, exp);
    end
  endtask

  // Reference decode from the requirement text; cls = -1 means illegal
  task automatic model(input logic [7:0] o, output int cls, output int am,
                       output int dst, output int flg, output string tag);
    int a, b, c;
    a = int'(o[7:5]); b = int'(o[4:2]); c = int'(o[1:0]);
    cls = -1; am = 0; dst = 0; flg = 0; tag = "R9";
    if (c == 1) begin
      tag = "R1";
      case (b)
        0: am = 8; 1: am = 3; 2: am = 2; 3: am = 5;
        4: am = 9; 5: am = 4; 6: am = 7; default: am = 6;
      endcase
      case (a)
        0, 1, 2: cls = 0;
        3: cls = 1; 4: cls = 5; 5: cls = 4; 6: cls = 3; default: cls = 2;
      endcase
      dst = (a == 4) ? 5 : (a == 6) ? 0 : 1;
      flg = (a != 4) ? 1 : 0;
      if (a == 4 && b == 2) begin
        cls = -1; tag = "R2";
      end
    end else if (c == 2) begin
      if (a < 4) begin
        tag = "R3";
        if (b == 1 || b == 2 || b == 3 || b == 5 || b == 7) begin
          cls = 6; flg = 1;
          am = (b == 1) ? 3 : (b == 2) ? 1 : (b == 3) ? 5 : (b == 5) ? 4 : 6;
          dst = (b == 2) ? 1 : 5;
        end
      end else begin
        tag = "R4";
        if (b == 2 && a == 4) begin cls = 8;  dst = 1; flg = 1; end
        if (b == 2 && a == 6) begin cls = 7;  dst = 2; flg = 1; end
        if (b == 2 && a == 7) begin cls = 12; dst = 0; flg = 0; end
        if (b == 6 && a == 4) begin cls = 8;  dst = 4; flg = 0; end
        if (b == 6 && a == 5) begin cls = 8;  dst = 2; flg = 1; end
      end
    end else if (c == 0) begin
      if (b == 4 && (a == 4 || a == 6 || a == 7)) begin
        tag = "R5"; cls = 9; am = 10; dst = 6;
      end else if (b == 2 && (a == 4 || a == 6 || a == 7)) begin
        tag = "R6"; cls = 7; dst = (a == 7) ? 2 : 3; flg = 1;
      end else if (b == 6 && a == 4) begin
        tag = "R6"; cls = 8; dst = 1; flg = 1;
      end else if (b == 6 && (a == 1 || a >= 5)) begin
        tag = "R7"; cls = 10; flg = 1;
      end else if (b == 0 && a < 4) begin
        tag = "R8"; cls = 11; dst = 6;
        am = (a == 1) ? 5 : 0;
        flg = (a == 0 || a == 2) ? 1 : 0;
      end
    end
    if (cls < 0) begin
      am = 0; dst = 0; flg = 0;
    end
  endtask

  task automatic check_op(input logic [7:0] o);
    int cls, am, dst, flg;
    string tag;
    logic [12:0] exp_vec;
    model(o, cls, am, dst, flg, tag);
    exp_vec = (cls < 0) ? 13'd0 : (13'd1 << cls);
    chk(tag, "illegal", o, int'(illegal), (cls < 0) ? 1 : 0);
    chk(tag, "class", o, int'(op_class), int'(exp_vec));
    chk(tag, "mode", o, int'(addr_mode), am);
    chk(tag, "dest", o, int'(dest), dst);
    chk("R11", "flag_upd", o, int'(flag_upd), flg);
    if (cls >= 0) chk("R10", "class_popcount", o, $countones(op_class), 1);
  endtask

  task automatic apply(input logic [7:0] o);
    @(posedge clk);
    opcode = o;
    @(negedge clk);
    check_op(o);
  endtask

  initial begin
    opcode = 8'h00;
    repeat (3) @(posedge clk);
    // Held during reset: 0x00 is break (R8)
    @(negedge clk);
    check_op(8'h00);
    rst = 1'b0;
    // Directed corners: override vs normal decode, group 11, store+immediate
    apply(8'h8A);  // R4 X-to-A in the accumulator-store slot
    apply(8'h9A);  // R4 X-to-stack-pointer
    apply(8'h96);  // R4 unmapped upper group 10 -> illegal
    apply(8'h89);  // R2 store immediate illegal
    apply(8'hF0);  // R5 branch on zero
    apply(8'h98);  // R6 Y-to-A
    apply(8'hB8);  // R7 clear overflow
    apply(8'h20);  // R8 call absolute
    apply(8'hFF);  // R9 group 11
    apply(8'h0A);  // R3 accumulator shift
    // Full sweep of the opcode space (R1 to R11)
    for (int i = 0; i < 256; i++) apply(8'(i));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule